// File: doc/BRIEF.md
# Audio Interface Owner and Notification Register Unit

This unit is the control and status register file of an audio streaming interface on a serial bus. A bus controller hands it one request per cycle on a plain register port: a quadlet read, a block read of a single quadlet, a quadlet write, or a 64-bit compare-swap. One cycle later it answers with read data or the old value, and flags an error when the request is not allowed.

The unit holds five registers:

- a 64-bit owner address, which only a compare-swap can change;
- an event notification word;
- a clock-select word;
- a stream-enable word;
- an extended clock-status word, which shows the live lock state of eleven clock sources together with sticky slip flags.

Events come from configuration-change inputs, from lock changes and from writes to the clock-select word. Each new event replaces the notification word. If an owner is present, the unit raises a send request that carries the owner address and the new word. It holds that request until a downstream sender acknowledges it.

A bus-reset pulse returns the owner to the no-owner value, stops the streams and drops any pending send.

Top module: `audio_owner_regs`

## Requirements
- R1: After reset the owner reads 0xFFFF0000_00000000 (high quadlet at byte 0x00, low quadlet at 0x04), the notification word (0x08), clock select (0x0C) and enable (0x10) read 0, and stream_run, notify_req and rsp_valid are low.
- R2: A compare-swap (op 3) at byte 0x00 answers with the old 64-bit owner one cycle after the request. It loads req_wdata into the owner only when the old value equals req_cmp.
- R3: Any request other than a read of a mapped quadlet, a quadlet write (op 1) to 0x0C or 0x10, or a compare-swap at 0x00 answers with rsp_err=1 and data 0, and changes no register. This covers a quadlet write to the owner, a write to the status word at 0x14, and any access to an unmapped offset.
- R4: A bus_reset pulse sets the owner to 0xFFFF0000_00000000, sets enable to 0 and drops notify_req in the next cycle.
- R5: In any cycle with at least one event, the notification word is replaced by exactly that cycle's event bits. The bits are: bit0 ev_rx_cfg, bit1 ev_tx_cfg, bit4 cur_locked changed, bit5 clock-select written, bit6 any src_locked bit changed.
- R6: After an event while the owner is not 0xFFFF0000_00000000, notify_req rises with notify_addr equal to the owner and notify_data equal to the notification word. It stays high until notify_ack. When there is no owner, no request is raised.
- R7: New events that arrive while a send is pending replace notify_data, and the request stays high.
- R8: A quadlet write to 0x0C stores the word (rate in bits 15:8, source in bits 7:0), drives clk_select, and raises event bit5.
- R9: A nonzero write to 0x10 sets stream_run high and a zero write clears it.
- R10: Bits 10:0 of the status word at 0x14 follow src_locked one cycle late. Any change of src_locked raises event bit6, and a change of cur_locked raises event bit4.
- R11: A pulse on src_slip sets status bit 16+i and raises no event. The bit stays set until a quadlet read (op 0) of 0x14 returns it; that read clears it.
- R12: A block read (op 2) of 0x14 returns the same word and leaves the slip bits set. A slip in the same cycle as a clearing read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_reset | input | 1 | Bus reset pulse |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 quadlet read, 1 quadlet write, 2 block read, 3 compare-swap |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 64 | Write data (low 32 bits) or swap value |
| req_cmp | input | 64 | Compare operand |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Read data or old owner |
| rsp_err | output | 1 | Request rejected |
| ev_rx_cfg | input | 1 | Receive configuration changed |
| ev_tx_cfg | input | 1 | Transmit configuration changed |
| cur_locked | input | 1 | Current source lock level |
| src_locked | input | 11 | Per-source lock levels |
| src_slip | input | 11 | Per-source slip pulses |
| notify_req | output | 1 | Notification send pending |
| notify_ack | input | 1 | Send accepted |
| notify_addr | output | 64 | Destination (owner) |
| notify_data | output | 32 | Notification word |
| clk_select | output | 32 | Clock-select word |
| stream_run | output | 1 | Streams enabled |

## Verification
The register port is tried with a table of mixed requests:

- compare-swaps with a wrong operand and with the right one, which separate a conditional update from an unconditional one;
- quadlet writes aimed at the owner and at the status word, which must be refused;
- a read of an unmapped offset.

The event logic is tried with single events, with several events in one cycle, and with events that arrive while a send is still pending. These show whether the word is replaced or merged, and whether the request is held.

Slip flags are read with block reads, with quadlet reads, and with a quadlet read that meets a new slip in the same cycle. These show which reads clear a flag and which order wins.

A bus reset is applied while a send is pending. Then an event follows with no owner, to show that the send is suppressed.

// File: rtl/audio_owner_regs.sv
module audio_owner_regs #(
  parameter int          NSRC     = 11,
  parameter int          AW       = 8,
  parameter logic [63:0] NO_OWNER = 64'hFFFF_0000_0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [63:0]     req_wdata,
  input  logic [63:0]     req_cmp,
  output logic            rsp_valid,
  output logic [63:0]     rsp_data,
  output logic            rsp_err,
  input  logic            ev_rx_cfg,
  input  logic            ev_tx_cfg,
  input  logic            cur_locked,
  input  logic [NSRC-1:0] src_locked,
  input  logic [NSRC-1:0] src_slip,
  output logic            notify_req,
  input  logic            notify_ack,
  output logic [63:0]     notify_addr,
  output logic [31:0]     notify_data,
  output logic [31:0]     clk_select,
  output logic            stream_run
);

  localparam logic [1:0] OP_QRD = 2'd0;
  localparam logic [1:0] OP_QWR = 2'd1;
  localparam logic [1:0] OP_BRD = 2'd2;
  localparam logic [1:0] OP_CSW = 2'd3;

  localparam logic [AW-1:0] A_OWN_HI = AW'(8'h00);
  localparam logic [AW-1:0] A_OWN_LO = AW'(8'h04);
  localparam logic [AW-1:0] A_NOTE   = AW'(8'h08);
  localparam logic [AW-1:0] A_CSEL   = AW'(8'h0C);
  localparam logic [AW-1:0] A_ENAB   = AW'(8'h10);
  localparam logic [AW-1:0] A_STAT   = AW'(8'h14);

  localparam int SLIP_LSB = 16;

  logic [63:0]     owner_q;
  logic [31:0]     note_q;
  logic [31:0]     csel_q;
  logic [31:0]     enab_q;
  logic [NSRC-1:0] lock_q;
  logic [NSRC-1:0] slip_q;
  logic            cur_q;
  logic            pend_q;

  logic        is_rd, hit, wr_ok, cs_ok, req_err;
  logic        csel_wr, enab_wr, slip_clr, swap_hit;
  logic [31:0] rd_word, stat_word, ev_bits;

  always_comb begin
    stat_word = '0;
    stat_word[NSRC-1:0] = lock_q;
    stat_word[SLIP_LSB +: NSRC] = slip_q;
  end

  always_comb begin
    hit = 1'b1;
    case (req_addr)
      A_OWN_HI: rd_word = owner_q[63:32];
      A_OWN_LO: rd_word = owner_q[31:0];
      A_NOTE:   rd_word = note_q;
      A_CSEL:   rd_word = csel_q;
      A_ENAB:   rd_word = enab_q;
      A_STAT:   rd_word = stat_word;
      default: begin
        rd_word = '0;
        hit     = 1'b0;
      end
    endcase
  end

  assign is_rd    = (req_op == OP_QRD) || (req_op == OP_BRD);
  assign wr_ok    = (req_op == OP_QWR) && (req_addr == A_CSEL || req_addr == A_ENAB);
  assign cs_ok    = (req_op == OP_CSW) && (req_addr == A_OWN_HI);
  assign req_err  = req_valid && !((is_rd && hit) || wr_ok || cs_ok);

  assign csel_wr  = req_valid && wr_ok && (req_addr == A_CSEL);
  assign enab_wr  = req_valid && wr_ok && (req_addr == A_ENAB);
  assign slip_clr = req_valid && (req_op == OP_QRD) && (req_addr == A_STAT);
  assign swap_hit = req_valid && cs_ok && (owner_q == req_cmp);

  always_comb begin
    ev_bits    = '0;
    ev_bits[0] = ev_rx_cfg;
    ev_bits[1] = ev_tx_cfg;
    ev_bits[4] = cur_locked != cur_q;
    ev_bits[5] = csel_wr;
    ev_bits[6] = src_locked != lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= NO_OWNER;
      enab_q  <= '0;
      pend_q  <= 1'b0;
    end else if (bus_reset) begin
      owner_q <= NO_OWNER;
      enab_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (swap_hit) owner_q <= req_wdata;
      if (enab_wr)  enab_q  <= req_wdata[31:0];
      if (swap_hit && req_wdata == NO_OWNER) pend_q <= 1'b0;
      else if (ev_bits != '0)                pend_q <= (owner_q != NO_OWNER);
      else if (notify_ack)                   pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      note_q <= '0;
      csel_q <= '0;
      lock_q <= '0;
      cur_q  <= 1'b0;
      slip_q <= '0;
    end else begin
      if (ev_bits != '0) note_q <= ev_bits;
      if (csel_wr)       csel_q <= req_wdata[31:0];
      lock_q <= src_locked;
      cur_q  <= cur_locked;
      slip_q <= (slip_q & ~{NSRC{slip_clr}}) | src_slip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_err;
      if (!req_valid || req_err) rsp_data <= '0;
      else if (cs_ok)            rsp_data <= owner_q;
      else if (is_rd)            rsp_data <= {32'b0, rd_word};
      else                       rsp_data <= '0;
    end
  end

  assign notify_req  = pend_q;
  assign notify_addr = owner_q;
  assign notify_data = note_q;
  assign clk_select  = csel_q;
  assign stream_run  = |enab_q;

  AST_NO_SEND_WITHOUT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    notify_req |-> owner_q != NO_OWNER); // R6

  AST_SEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_req && !notify_ack && !bus_reset && !(req_valid && req_op == OP_CSW)) |=> notify_req); // R6

  AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (owner_q == NO_OWNER) && !stream_run && !notify_req); // R4

  AST_OWNER_ONLY_BY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_reset && !(req_valid && req_op == OP_CSW)) |=> $stable(owner_q)); // R3

  AST_RESPONSE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_SLIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!slip_clr) |=> ((slip_q & $past(slip_q)) == $past(slip_q))); // R11

  AST_SLIP_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|slip_q) && !$past(ev_rx_cfg || ev_tx_cfg || csel_wr) && $stable(lock_q) && $stable(cur_q)
     && !$past(notify_req)) |-> !notify_req); // R11

endmodule

// File: tb/audio_owner_regs_tb.sv
`timescale 1ns/1ps
module audio_owner_regs_tb_top;
  localparam logic [63:0] NOWN = 64'hFFFF_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [7:0] req_addr = '0;
  logic [63:0] req_wdata = '0, req_cmp = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_data;
  logic ev_rx_cfg = 1'b0, ev_tx_cfg = 1'b0, cur_locked = 1'b0;
  logic [10:0] src_locked = '0, src_slip = '0;
  logic notify_req, notify_ack = 1'b0;
  logic [63:0] notify_addr;
  logic [31:0] notify_data, clk_select;
  logic stream_run;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  audio_owner_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .ev_rx_cfg(ev_rx_cfg), .ev_tx_cfg(ev_tx_cfg), .cur_locked(cur_locked),
    .src_locked(src_locked), .src_slip(src_slip),
    .notify_req(notify_req), .notify_ack(notify_ack),
    .notify_addr(notify_addr), .notify_data(notify_data),
    .clk_select(clk_select), .stream_run(stream_run));

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [63:0] wd;
    logic [63:0] cmp;
    logic [63:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h00, 64'h0, 64'h0, 64'hFFFF_0000, 1'b0},
    '{2'd0, 8'h04, 64'h0, 64'h0, 64'h0, 1'b0},
    '{2'd3, 8'h00, 64'h1111, 64'h1234, NOWN, 1'b0},
    '{2'd0, 8'h00, 64'h0, 64'h0, 64'hFFFF_0000, 1'b0},
    '{2'd3, 8'h00, 64'hFFC1_0000_1000_0000, NOWN, NOWN, 1'b0},
    '{2'd0, 8'h04, 64'h0, 64'h0, 64'h1000_0000, 1'b0},
    '{2'd1, 8'h00, 64'h0, 64'h0, 64'h0, 1'b1},
    '{2'd0, 8'h00, 64'h0, 64'h0, 64'hFFC1_0000, 1'b0},
    '{2'd1, 8'h14, 64'h7, 64'h0, 64'h0, 1'b1},
    '{2'd1, 8'h0C, 64'h40C, 64'h0, 64'h0, 1'b0},
    '{2'd0, 8'h0C, 64'h0, 64'h0, 64'h40C, 1'b0},
    '{2'd0, 8'h08, 64'h0, 64'h0, 64'h20, 1'b0},
    '{2'd2, 8'h18, 64'h0, 64'h0, 64'h0, 1'b1}
  };
  localparam string VTAG [NV] = '{"R1","R1","R2","R2","R2","R2","R3","R3","R3","R8","R8","R5","R3"};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] op, input logic [7:0] a, input logic [63:0] wd, input logic [63:0] cmp);
    req_op = op; req_addr = a; req_wdata = wd; req_cmp = cmp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 notify_req", notify_req, 0);
    chk("R1 stream_run", stream_run, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 clk_select", clk_select, 0);

    for (int i = 0; i < NV; i++) begin
      req(VEC[i].op, VEC[i].addr, VEC[i].wd, VEC[i].cmp);
      chk({VTAG[i], " rsp_valid"}, rsp_valid, 1);
      chk({VTAG[i], " rsp_err"}, rsp_err, VEC[i].err);
      chk({VTAG[i], " rsp_data"}, rsp_data, VEC[i].exp);
    end
    chk("R8 clk_select", clk_select, 32'h40C);

    // R6 pending send from the clock-select write
    chk("R6 notify_req", notify_req, 1);
    chk("R6 notify_addr", notify_addr, 64'hFFC1_0000_1000_0000);
    chk("R6 notify_data", notify_data, 32'h20);
    tick();
    chk("R6 held", notify_req, 1);
    notify_ack = 1'b1; tick(); notify_ack = 1'b0;
    chk("R6 acked", notify_req, 0);

    // R10 lock change
    src_locked = 11'h005; tick();
    chk("R10 notify_data", notify_data, 32'h40);
    chk("R10 notify_req", notify_req, 1);
    req(2'd0, 8'h14, 0, 0);
    chk("R10 status", rsp_data, 64'h005);

    // R5 and R7 multiple events while pending
    cur_locked = 1'b1; ev_rx_cfg = 1'b1; tick(); ev_rx_cfg = 1'b0;
    chk("R7 notify_data", notify_data, 32'h11);
    chk("R7 notify_req", notify_req, 1);
    ev_tx_cfg = 1'b1; tick(); ev_tx_cfg = 1'b0;
    chk("R5 notify_data", notify_data, 32'h02);
    notify_ack = 1'b1; tick(); notify_ack = 1'b0;

    // R11 and R12 slip flags
    src_slip = 11'h008; tick(); src_slip = '0;
    tick();
    chk("R11 no event", notify_req, 0);
    chk("R11 note kept", notify_data, 32'h02);
    req(2'd2, 8'h14, 0, 0);
    chk("R12 block read", rsp_data, 64'h0008_0005);
    req(2'd2, 8'h14, 0, 0);
    chk("R12 block read again", rsp_data, 64'h0008_0005);
    req(2'd0, 8'h14, 0, 0);
    chk("R11 quadlet read", rsp_data, 64'h0008_0005);
    src_slip = 11'h001;
    req(2'd0, 8'h14, 0, 0);
    src_slip = '0;
    chk("R11 cleared", rsp_data, 64'h0000_0005);
    req(2'd0, 8'h14, 0, 0);
    chk("R12 same-cycle slip kept", rsp_data, 64'h0001_0005);

    // R9 enable
    req(2'd1, 8'h10, 64'h5, 0);
    chk("R9 run on", stream_run, 1);
    req(2'd1, 8'h10, 64'h0, 0);
    chk("R9 run off", stream_run, 0);
    req(2'd1, 8'h10, 64'h7, 0);
    chk("R9 run on again", stream_run, 1);

    // R4 bus reset with a pending send
    ev_rx_cfg = 1'b1; tick(); ev_rx_cfg = 1'b0;
    chk("R6 pending before reset", notify_req, 1);
    bus_reset = 1'b1; tick(); bus_reset = 1'b0;
    chk("R4 notify_req", notify_req, 0);
    chk("R4 stream_run", stream_run, 0);
    req(2'd0, 8'h00, 0, 0);
    chk("R4 owner hi", rsp_data, 64'hFFFF_0000);
    req(2'd0, 8'h04, 0, 0);
    chk("R4 owner lo", rsp_data, 64'h0);

    // R6 suppressed with no owner
    ev_tx_cfg = 1'b1; tick(); ev_tx_cfg = 1'b0;
    chk("R6 suppressed", notify_req, 0);
    chk("R5 word updated", notify_data, 32'h02);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule